// File: doc/BRIEF.md
# Interrupt Cause and Mask Controller

This block gathers interrupt events into three cause registers and folds them, through per-output mask registers, into two interrupt request lines.

- **Main cause.** Hardware sets its bits with one-cycle event pulses. Software clears a bit by writing a word that holds 0 in that position. Three of its bits (0, 30 and 31) cannot be changed by a write.
- **High cause.** It follows a set of hardware level inputs. Software can read it but cannot write it.
- **Serial-DMA cause.** It takes event pulses and an AND-style clear, like the main cause. It also has a second byte address at which any write wipes the whole register.

Each of the two interrupt outputs has its own main mask and its own high mask. An output is raised when either masked cause is non-zero. The serial-DMA cause has its own mask and drives its own request line. Two serial mask registers and a read-only serial summary word are also mapped in the register space.

Software reaches the registers through a 32-bit request port that has a registered read response. The bus side and the register side use opposite byte order. Every 32-bit word is therefore byte-reversed on the way in and again on the way out.

Top module: `intr_cause_ctrl`

## Requirements
- R1: After synchronous reset, all cause and mask registers read as zero, all three interrupt outputs are low and `rsp_valid` is low.
- R2: A write to the main cause register (offset 0xC18) clears each cause bit whose written bit is 0 and leaves each bit whose written bit is 1 unchanged.
- R3: Bits 0, 30 and 31 of the main cause register keep their value across any write to it.
- R4: The high cause register (0xC98) holds the `high_level` input as sampled one cycle earlier, and writes to it have no effect.
- R5: The mask registers can be written and read back. Output 0 has its main mask at 0xC1C and its high mask at 0xC9C. Output 1 has its main mask at 0xC24 and its high mask at 0xCA4.
- R6: `irq_out[n]` is high exactly when (main cause AND main mask n) or (high cause AND high mask n) is non-zero. It follows a register change by one clock cycle.
- R7: The serial-DMA cause (0x103A10) reads back its contents and is AND-cleared by a write. Its mask sits at 0x103A90. `sdma_irq` is high one cycle after (cause AND mask) becomes non-zero.
- R8: Any write to byte address 0x103A13 clears the entire serial-DMA cause, whatever the data.
- R9: The serial mask registers at 0x103A80 and 0x103A88 can be written and read back. The serial summary at 0x103A00 returns the `ser_summary` input, and writes to it have no effect.
- R10: The bus word is byte-reversed before it reaches a register, so bus bits [7:0] land in register bits [31:24]. Read data is byte-reversed the same way on the way out.
- R11: When an event pulse and a software clear hit the same cause bit in the same cycle, the bit ends up set.
- R12: A read returns its data on `rsp_rdata` with `rsp_valid` high one cycle after the request. Reads of unmapped offsets return zero, and writes to unmapped offsets change no register.
- R13: An event pulse on `evt_main_set` or `evt_sdma_set` sets the matching cause bits on the next clock edge, and those bits stay set until they are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Byte offset of the register |
| req_wdata | input | 32 | Write data in bus byte order |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data in bus byte order |
| evt_main_set | input | 32 | One-cycle event pulses that set main cause bits |
| evt_sdma_set | input | 32 | One-cycle event pulses that set serial-DMA cause bits |
| high_level | input | 32 | Level sources for the high cause register |
| ser_summary | input | 32 | Serial cause summary value, read-only |
| irq_out | output | 2 | Interrupt request per output |
| sdma_irq | output | 1 | Serial-DMA interrupt request |

## Verification
Two functions can fall in the same cycle: a hardware event pulse and a software AND-clear of the same cause register. The bench provokes this by raising an event bit on the very clock edge at which a write of all zeros reaches the main cause. It then reads the register and expects the event bit to be set, alongside the three protected bits. The bench also checks interrupt latency by sampling the outputs at the first and the second falling edge after a mask write. It expects the old level at the first and the new level at the second.

// File: rtl/ictl_pkg.sv
package ictl_pkg;
    parameter int AW      = 24;
    parameter int DW      = 32;
    parameter int NUM_OUT = 2;

    typedef logic [DW-1:0] word_t;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_MAIN_CAUSE, SEL_HIGH_CAUSE,
        SEL_M0_MAIN, SEL_M0_HIGH, SEL_M1_MAIN, SEL_M1_HIGH,
        SEL_SER_SUM, SEL_SER_MASK0, SEL_SER_MASK1,
        SEL_SDMA_CAUSE, SEL_SDMA_WIPE, SEL_SDMA_MASK
    } reg_sel_e;

    typedef struct packed {
        logic     wr;
        reg_sel_e sel;
        word_t    data;
    } reg_cmd_t;

    localparam logic [AW-1:0] OFS_MAIN_CAUSE = 24'h000C18;
    localparam logic [AW-1:0] OFS_HIGH_CAUSE = 24'h000C98;
    localparam logic [AW-1:0] OFS_M0_MAIN    = 24'h000C1C;
    localparam logic [AW-1:0] OFS_M0_HIGH    = 24'h000C9C;
    localparam logic [AW-1:0] OFS_M1_MAIN    = 24'h000C24;
    localparam logic [AW-1:0] OFS_M1_HIGH    = 24'h000CA4;
    localparam logic [AW-1:0] OFS_SER_SUM    = 24'h103A00;
    localparam logic [AW-1:0] OFS_SER_MASK0  = 24'h103A80;
    localparam logic [AW-1:0] OFS_SER_MASK1  = 24'h103A88;
    localparam logic [AW-1:0] OFS_SDMA_CAUSE = 24'h103A10;
    localparam logic [AW-1:0] OFS_SDMA_WIPE  = 24'h103A13;
    localparam logic [AW-1:0] OFS_SDMA_MASK  = 24'h103A90;

    localparam word_t MAIN_RO_MASK = 32'hC000_0001;

    function automatic word_t swap_bytes(input word_t w);
        word_t r;
        for (int b = 0; b < DW/8; b++)
            r[8*b +: 8] = w[DW-8-8*b +: 8];
        return r;
    endfunction

    function automatic reg_sel_e decode_addr(input logic [AW-1:0] a);
        case (a)
            OFS_MAIN_CAUSE: return SEL_MAIN_CAUSE;
            OFS_HIGH_CAUSE: return SEL_HIGH_CAUSE;
            OFS_M0_MAIN:    return SEL_M0_MAIN;
            OFS_M0_HIGH:    return SEL_M0_HIGH;
            OFS_M1_MAIN:    return SEL_M1_MAIN;
            OFS_M1_HIGH:    return SEL_M1_HIGH;
            OFS_SER_SUM:    return SEL_SER_SUM;
            OFS_SER_MASK0:  return SEL_SER_MASK0;
            OFS_SER_MASK1:  return SEL_SER_MASK1;
            OFS_SDMA_CAUSE: return SEL_SDMA_CAUSE;
            OFS_SDMA_WIPE:  return SEL_SDMA_WIPE;
            OFS_SDMA_MASK:  return SEL_SDMA_MASK;
            default:        return SEL_NONE;
        endcase
    endfunction
endpackage

// File: rtl/ictl_cause_bank.sv
module ictl_cause_bank
    import ictl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  reg_cmd_t cmd,
    input  word_t    evt_main,
    input  word_t    evt_sdma,
    input  word_t    high_level,
    output word_t    main_cause,
    output word_t    high_cause,
    output word_t    sdma_cause
);
    word_t main_q, high_q, sdma_q;
    word_t main_d, sdma_d;

    always_comb begin
        main_d = main_q;
        if (cmd.wr && cmd.sel == SEL_MAIN_CAUSE)
            main_d = main_q & (cmd.data | MAIN_RO_MASK);
        // pulses applied last: an event beats a same-cycle clear
        main_d = main_d | evt_main;

        sdma_d = sdma_q;
        if (cmd.wr && cmd.sel == SEL_SDMA_CAUSE)
            sdma_d = sdma_q & cmd.data;
        else if (cmd.wr && cmd.sel == SEL_SDMA_WIPE)
            sdma_d = '0;
        sdma_d = sdma_d | evt_sdma;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            main_q <= '0;
            high_q <= '0;
            sdma_q <= '0;
        end else begin
            main_q <= main_d;
            high_q <= high_level;
            sdma_q <= sdma_d;
        end
    end

    assign main_cause = main_q;
    assign high_cause = high_q;
    assign sdma_cause = sdma_q;

    assert_ro_bits_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd.wr && cmd.sel == SEL_MAIN_CAUSE && evt_main == '0)
        |=> ((main_q & MAIN_RO_MASK) == $past(main_q & MAIN_RO_MASK)));

    assert_high_ignores_wr_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd.wr && cmd.sel == SEL_HIGH_CAUSE) |=> (high_q == $past(high_level)));

    assert_sdma_wipe_R8: assert property (@(posedge clk) disable iff (rst)
        (cmd.wr && cmd.sel == SEL_SDMA_WIPE && evt_sdma == '0) |=> (sdma_q == '0));

    assert_set_wins_R11: assert property (@(posedge clk) disable iff (rst)
        (evt_main != '0) |=> ((main_q & $past(evt_main)) == $past(evt_main)));

    assert_sdma_set_R13: assert property (@(posedge clk) disable iff (rst)
        (evt_sdma != '0) |=> ((sdma_q & $past(evt_sdma)) == $past(evt_sdma)));
endmodule

// File: rtl/ictl_mask_bank.sv
module ictl_mask_bank
    import ictl_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  reg_cmd_t                cmd,
    output logic [NUM_OUT-1:0][DW-1:0] main_mask,
    output logic [NUM_OUT-1:0][DW-1:0] high_mask,
    output word_t                   ser_mask0,
    output word_t                   ser_mask1,
    output word_t                   sdma_mask
);
    localparam reg_sel_e MAIN_SEL [NUM_OUT] = '{SEL_M0_MAIN, SEL_M1_MAIN};
    localparam reg_sel_e HIGH_SEL [NUM_OUT] = '{SEL_M0_HIGH, SEL_M1_HIGH};

    logic any_mask_wr;

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
        always_ff @(posedge clk) begin
            if (rst) begin
                main_mask[g] <= '0;
                high_mask[g] <= '0;
            end else if (cmd.wr) begin
                if (cmd.sel == MAIN_SEL[g]) main_mask[g] <= cmd.data;
                if (cmd.sel == HIGH_SEL[g]) high_mask[g] <= cmd.data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ser_mask0 <= '0;
            ser_mask1 <= '0;
            sdma_mask <= '0;
        end else if (cmd.wr) begin
            case (cmd.sel)
                SEL_SER_MASK0: ser_mask0 <= cmd.data;
                SEL_SER_MASK1: ser_mask1 <= cmd.data;
                SEL_SDMA_MASK: sdma_mask <= cmd.data;
                default: ;
            endcase
        end
    end

    always_comb begin
        any_mask_wr = cmd.wr && (cmd.sel inside {SEL_M0_MAIN, SEL_M0_HIGH,
                      SEL_M1_MAIN, SEL_M1_HIGH, SEL_SER_MASK0, SEL_SER_MASK1, SEL_SDMA_MASK});
    end

    assert_mask_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !any_mask_wr |=> ($stable(main_mask) && $stable(high_mask) && $stable(sdma_mask)
                          && $stable(ser_mask0) && $stable(ser_mask1)));
endmodule

// File: rtl/ictl_irq_eval.sv
module ictl_irq_eval
    import ictl_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  word_t                      main_cause,
    input  word_t                      high_cause,
    input  word_t                      sdma_cause,
    input  logic [NUM_OUT-1:0][DW-1:0] main_mask,
    input  logic [NUM_OUT-1:0][DW-1:0] high_mask,
    input  word_t                      sdma_mask,
    output logic [NUM_OUT-1:0]         irq_q,
    output logic                       sdma_irq_q
);
    for (genvar g = 0; g < NUM_OUT; g++) begin : g_irq
        always_ff @(posedge clk) begin
            if (rst) irq_q[g] <= 1'b0;
            else     irq_q[g] <= (|(main_cause & main_mask[g])) | (|(high_cause & high_mask[g]));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) sdma_irq_q <= 1'b0;
        else     sdma_irq_q <= |(sdma_cause & sdma_mask);
    end

    assert_irq_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (main_cause == '0 && high_cause == '0) |=> (irq_q == '0));

    assert_sdma_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (sdma_cause == '0) |=> !sdma_irq_q);
endmodule

// File: rtl/ictl_bus_if.sv
module ictl_bus_if
    import ictl_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_valid,
    input  logic                       req_write,
    input  logic [AW-1:0]              req_addr,
    input  word_t                      req_wdata,
    input  word_t                      main_cause,
    input  word_t                      high_cause,
    input  word_t                      sdma_cause,
    input  logic [NUM_OUT-1:0][DW-1:0] main_mask,
    input  logic [NUM_OUT-1:0][DW-1:0] high_mask,
    input  word_t                      ser_mask0,
    input  word_t                      ser_mask1,
    input  word_t                      sdma_mask,
    input  word_t                      ser_summary,
    output reg_cmd_t                   cmd,
    output logic                       rsp_valid,
    output word_t                      rsp_rdata
);
    reg_sel_e sel;
    word_t    rd_val;

    always_comb begin
        sel      = decode_addr(req_addr);
        cmd.wr   = req_valid && req_write;
        cmd.sel  = sel;
        cmd.data = swap_bytes(req_wdata);
    end

    always_comb begin
        case (sel)
            SEL_MAIN_CAUSE: rd_val = main_cause;
            SEL_HIGH_CAUSE: rd_val = high_cause;
            SEL_M0_MAIN:    rd_val = main_mask[0];
            SEL_M0_HIGH:    rd_val = high_mask[0];
            SEL_M1_MAIN:    rd_val = main_mask[1];
            SEL_M1_HIGH:    rd_val = high_mask[1];
            SEL_SER_SUM:    rd_val = ser_summary;
            SEL_SER_MASK0:  rd_val = ser_mask0;
            SEL_SER_MASK1:  rd_val = ser_mask1;
            SEL_SDMA_CAUSE: rd_val = sdma_cause;
            SEL_SDMA_MASK:  rd_val = sdma_mask;
            default:        rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid && !req_write;
            rsp_rdata <= (req_valid && !req_write) ? swap_bytes(rd_val) : '0;
        end
    end

    assert_rsp_latency_R12: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> rsp_valid);

    assert_unmapped_zero_R12: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && sel == SEL_NONE) |=> (rsp_rdata == '0));
endmodule

// File: rtl/intr_cause_ctrl.sv
module intr_cause_ctrl
    import ictl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [AW-1:0]      req_addr,
    input  logic [DW-1:0]      req_wdata,
    output logic               rsp_valid,
    output logic [DW-1:0]      rsp_rdata,
    input  logic [DW-1:0]      evt_main_set,
    input  logic [DW-1:0]      evt_sdma_set,
    input  logic [DW-1:0]      high_level,
    input  logic [DW-1:0]      ser_summary,
    output logic [NUM_OUT-1:0] irq_out,
    output logic               sdma_irq
);
    reg_cmd_t cmd;
    word_t    main_cause, high_cause, sdma_cause;
    word_t    ser_mask0, ser_mask1, sdma_mask;
    logic [NUM_OUT-1:0][DW-1:0] main_mask, high_mask;

    ictl_bus_if u_bus (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .main_cause(main_cause), .high_cause(high_cause), .sdma_cause(sdma_cause),
        .main_mask(main_mask), .high_mask(high_mask),
        .ser_mask0(ser_mask0), .ser_mask1(ser_mask1), .sdma_mask(sdma_mask),
        .ser_summary(ser_summary),
        .cmd(cmd), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    ictl_cause_bank u_cause (
        .clk(clk), .rst(rst), .cmd(cmd),
        .evt_main(evt_main_set), .evt_sdma(evt_sdma_set), .high_level(high_level),
        .main_cause(main_cause), .high_cause(high_cause), .sdma_cause(sdma_cause)
    );

    ictl_mask_bank u_mask (
        .clk(clk), .rst(rst), .cmd(cmd),
        .main_mask(main_mask), .high_mask(high_mask),
        .ser_mask0(ser_mask0), .ser_mask1(ser_mask1), .sdma_mask(sdma_mask)
    );

    ictl_irq_eval u_irq (
        .clk(clk), .rst(rst),
        .main_cause(main_cause), .high_cause(high_cause), .sdma_cause(sdma_cause),
        .main_mask(main_mask), .high_mask(high_mask), .sdma_mask(sdma_mask),
        .irq_q(irq_out), .sdma_irq_q(sdma_irq)
    );
endmodule

// File: tb/intr_cause_ctrl_tb_top.sv
module intr_cause_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [23:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [31:0] evt_main_set = '0, evt_sdma_set = '0, high_level = '0, ser_summary = '0;
    logic [1:0]  irq_out;
    logic        sdma_irq;

    int checks = 0;
    int fails  = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;   // 50 MHz

    intr_cause_ctrl dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .evt_main_set(evt_main_set), .evt_sdma_set(evt_sdma_set),
        .high_level(high_level), .ser_summary(ser_summary), .irq_out(irq_out),
        .sdma_irq(sdma_irq)
    );

    function automatic logic [31:0] rev(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read data as responses appear
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (exp_q.size() == 0) check("R12 unexpected response", 32'h1, 32'h0);
            else check(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
        end
    end

    // register-side value, swapped onto the bus
    task automatic wr(input logic [23:0] a, input logic [31:0] v);
        wr_raw(a, rev(v));
    endtask

    task automatic wr_raw(input logic [23:0] a, input logic [31:0] bus);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = bus;
        @(negedge clk);
        req_valid = 0; req_write = 0;
    endtask

    task automatic rd(input logic [23:0] a, input logic [31:0] v, input string tag);
        rd_raw(a, rev(v), tag);
    endtask

    task automatic rd_raw(input logic [23:0] a, input logic [31:0] bus, input string tag);
        @(negedge clk);
        exp_q.push_back(bus); tag_q.push_back(tag);
        req_valid = 1; req_write = 0; req_addr = a;
        @(negedge clk);
        req_valid = 0;
    endtask

    initial begin
        #4000000;
        fails++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        check("R1 irq_out", {30'd0, irq_out}, 32'd0);
        check("R1 sdma_irq", {31'd0, sdma_irq}, 32'd0);
        check("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
        rd(24'h000C18, 32'h0, "R1 main cause");
        rd(24'h000C1C, 32'h0, "R1 mask0 main");
        // R13 event pulses set main cause
        @(negedge clk); evt_main_set = 32'hFFFF_FFFF;
        @(negedge clk); evt_main_set = '0;
        rd(24'h000C18, 32'hFFFF_FFFF, "R13 main after pulse");
        // R2/R3 AND-clear with protected bits
        wr(24'h000C18, 32'h0000_FF00);
        rd(24'h000C18, 32'hC000_FF01, "R2 R3 main after clear");
        // R5 and R6 latency
        wr(24'h000C1C, 32'h0000_0100);
        check("R6 irq0 one cycle before", {31'd0, irq_out[0]}, 32'd0);
        @(negedge clk);
        check("R6 irq0 asserted", {31'd0, irq_out[0]}, 32'd1);
        check("R6 irq1 stays low", {31'd0, irq_out[1]}, 32'd0);
        rd(24'h000C1C, 32'h0000_0100, "R5 mask0 main readback");
        wr(24'h000C18, 32'h0);
        @(negedge clk);
        check("R6 irq0 drops", {31'd0, irq_out[0]}, 32'd0);
        rd(24'h000C18, 32'hC000_0001, "R3 protected bits survive zero write");
        // R10 byte order: raw bus 0x01000000 becomes register bit 0
        wr_raw(24'h000C24, 32'h0100_0000);
        @(negedge clk);
        check("R10 irq1 from swapped mask", {31'd0, irq_out[1]}, 32'd1);
        rd_raw(24'h000C24, 32'h0100_0000, "R10 raw readback");
        wr(24'h000C24, 32'h0);
        // R4 high cause
        @(negedge clk); high_level = 32'h0000_0010;
        wr(24'h000C98, 32'h0);
        rd(24'h000C98, 32'h0000_0010, "R4 high ignores write");
        wr(24'h000CA4, 32'h0000_0010);
        @(negedge clk);
        check("R6 irq1 from high", {31'd0, irq_out[1]}, 32'd1);
        rd(24'h000CA4, 32'h0000_0010, "R5 mask1 high readback");
        rd(24'h000C9C, 32'h0, "R5 mask0 high untouched");
        // R11 set wins over same-cycle clear
        @(negedge clk);
        evt_main_set = 32'h0000_0020;
        req_valid = 1; req_write = 1; req_addr = 24'h000C18; req_wdata = 32'h0;
        @(negedge clk);
        evt_main_set = '0; req_valid = 0; req_write = 0;
        rd(24'h000C18, 32'hC000_0021, "R11 set beats clear");
        // R7 / R8 serial-DMA cause
        @(negedge clk); evt_sdma_set = 32'h0000_F0F0;
        @(negedge clk); evt_sdma_set = '0;
        rd(24'h103A10, 32'h0000_F0F0, "R13 sdma after pulse");
        wr(24'h103A10, 32'h0000_00F0);
        rd(24'h103A10, 32'h0000_00F0, "R7 sdma and-clear");
        wr(24'h103A90, 32'h0000_0010);
        @(negedge clk);
        check("R7 sdma_irq", {31'd0, sdma_irq}, 32'd1);
        rd(24'h103A90, 32'h0000_0010, "R7 sdma mask readback");
        wr(24'h103A13, 32'h0000_0000);
        @(negedge clk);
        check("R8 sdma_irq after wipe", {31'd0, sdma_irq}, 32'd0);
        rd(24'h103A10, 32'h0, "R8 sdma wiped");
        // R9 serial masks and summary
        ser_summary = 32'h0000_0033;
        wr(24'h103A80, 32'h0000_A5A5);
        wr(24'h103A88, 32'h0000_5A5A);
        wr(24'h103A00, 32'hFFFF_FFFF);
        rd(24'h103A80, 32'h0000_A5A5, "R9 ser mask0");
        rd(24'h103A88, 32'h0000_5A5A, "R9 ser mask1");
        rd(24'h103A00, 32'h0000_0033, "R9 summary read-only");
        // R12 unmapped
        wr(24'h000500, 32'hFFFF_FFFF);
        rd(24'h000500, 32'h0, "R12 unmapped read");
        rd(24'h000C1C, 32'h0000_0100, "R12 mask0 main untouched");
        rd(24'h000C18, 32'hC000_0021, "R12 main untouched");
        repeat (3) @(negedge clk);
        check("R12 all responses seen", exp_q.size(), 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule